// File: doc/BRIEF.md
# Reload-Counter Serial Clock Generator

This block derives the master-side serial clock of a clock-synchronous serial port from the bus clock. It divides the bus clock by an integer ratio equal to the 15-bit reload value plus one. For each serial clock transition it also produces a one-bus-cycle strobe, so a shifter can change or sample data on the correct edge without running its own edge detector. Two identical divider channels run from the same inputs. One drives the transmit shifter and the other the receive shifter, and each channel keeps its own counter.

A period starts with a falling edge, so the LOW phase comes first and the HIGH phase follows. The clock rests HIGH. When the ratio is even, the two phases have equal length. When the ratio is odd, the inversion input decides which phase gets the extra bus cycle. The reload value and the inversion bit are captured at the start of every period, so a change made while the clock runs takes effect at the next falling edge. A reload value of 0 stops the clock at the end of the current period. Dropping the enable returns the clock to rest on the next cycle. Reload values of 3 or more are the intended operating range. Values 1 and 2 still produce a well-formed clock.

Each channel is a three-state machine. The states are IDLE (clock HIGH, counter cleared), LOW (first phase) and HIGH (second phase). The transitions are:
- start: IDLE to LOW, taken when the enable is high and the reload value is not zero.
- mid: LOW to HIGH, taken when the LOW count is used up.
- wrap: HIGH to LOW, taken when the HIGH count is used up and the reload value is not zero.
- stop: HIGH to IDLE, taken when the HIGH count is used up and the reload value is zero.
- abort: LOW or HIGH to IDLE, taken whenever the enable is low.

Top module: `sclk_reload_gen`

## Requirements
- R1: With a constant reload value V ≥ 1, consecutive falling edges of the serial clock are exactly V+1 bus cycles apart, and the LOW and HIGH widths add up to V+1. This holds for the full 15-bit range (for example, V=832 gives 833 cycles).
- R2: If the enable rises while the reload value is 0, the clock stays HIGH and neither strobe fires.
- R3: For an odd reload value V, the LOW and HIGH phases each last (V+1)/2 cycles.
- R4: For an even reload value V with the inversion bit 0, the HIGH phase lasts V/2+1 cycles and the LOW phase V/2.
- R5: For an even reload value V with the inversion bit 1, the LOW phase lasts V/2+1 cycles and the HIGH phase V/2.
- R6: On every cycle, the transmit and receive channels show the same clock level and the same strobes.
- R7: One cycle after the enable is sampled low, the clock is HIGH and the fall strobe is 0. Both stay that way while the enable remains low.
- R8: A reload value changed during a period does not alter that period. The new value sets the widths starting with the next falling edge.
- R9: The rise strobe is high only in the first cycle the clock is HIGH after being LOW. The fall strobe is high only in the first cycle the clock is LOW after being HIGH. The two strobes are never high together, and an abort out of LOW also raises the rise strobe.
- R10: The first falling edge, with its fall strobe, appears one cycle after the enable is first sampled high with a nonzero reload value.
- R11: If the reload value is 0 when a HIGH phase ends, the clock stays HIGH with no further strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low returns both channels to IDLE |
| reload | input | 15 | Division reload value; ratio = reload + 1; 0 stops |
| invert | input | 1 | For odd ratios: 0 gives the extra cycle to HIGH, 1 to LOW |
| tx_sck | output | 1 | Transmit-side serial clock level |
| tx_rise | output | 1 | Transmit-side rising-edge strobe |
| tx_fall | output | 1 | Transmit-side falling-edge strobe |
| rx_sck | output | 1 | Receive-side serial clock level |
| rx_rise | output | 1 | Receive-side rising-edge strobe |
| rx_fall | output | 1 | Receive-side falling-edge strobe |

## Verification
The divider is swept over every reload value from 1 to 40 with both inversion settings. This covers equal halves (odd reload), longer HIGH phases and longer LOW phases. It also catches off-by-one errors in the half-width split that only show for one ratio parity. The two real baud examples (129 and 832) confirm that the full counter width is used. Separate runs cover the boundary events. The first is a reload change in the middle of a period, which shows whether the new value is captured at the period boundary or applied mid-phase. The others are a zero reload written while the clock runs, a zero reload at start, and an enable dropped during the LOW phase, which show the stop, refuse-to-start and abort paths with their strobes.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } sck_state_e;

endpackage

// File: rtl/sclk_phase_split.sv
// Splits a division ratio (reload + 1) into LOW and HIGH phase lengths,
// returned as terminal counts (length - 1).
module sclk_phase_split #(
    parameter int RW = 15
) (
    input  logic [RW-1:0] reload_val,
    input  logic          invert_val,
    output logic [RW-1:0] lo_last,
    output logic [RW-1:0] hi_last
);
    localparam logic [RW-1:0] ONE = RW'(1);

    logic [RW:0]   ratio;
    logic [RW-1:0] half;
    logic          odd;
    logic [RW-1:0] lo_len;
    logic [RW-1:0] hi_len;

    always_comb begin
        ratio  = {1'b0, reload_val} + {{RW{1'b0}}, 1'b1};
        half   = ratio[RW:1];
        odd    = ratio[0];
        lo_len = half + {{(RW-1){1'b0}}, (odd & invert_val)};
        hi_len = half + {{(RW-1){1'b0}}, (odd & ~invert_val)};
        lo_last = lo_len - ONE;
        hi_last = hi_len - ONE;
    end

endmodule

// File: rtl/sclk_chan.sv
// One divider channel: IDLE / LOW / HIGH state machine with edge strobes.
module sclk_chan
    import sclk_pkg::*;
#(
    parameter int RW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [RW-1:0] reload_in,
    input  logic          invert_in,
    output logic          sck_o,
    output logic          rise_o,
    output logic          fall_o
);
    localparam logic [RW-1:0] ONE  = RW'(1);
    localparam logic [RW-1:0] ZERO = '0;
    localparam int            CW   = RW + 2;

    sck_state_e    st_q, st_d;
    logic [RW-1:0] cnt_q, cnt_d;
    logic [RW-1:0] cur_rl_q;
    logic          cur_inv_q;
    logic          ld;
    logic [RW-1:0] lo_last, hi_last;
    logic          sck_q, rise_q, fall_q;

    // Phase lengths of the period in progress (captured settings)
    sclk_phase_split #(.RW(RW)) u_split (
        .reload_val (cur_rl_q),
        .invert_val (cur_inv_q),
        .lo_last    (lo_last),
        .hi_last    (hi_last)
    );

    // Next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        ld    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                cnt_d = ZERO;
                if (en && (reload_in != ZERO)) begin
                    st_d = ST_LOW;          // start
                    ld   = 1'b1;
                end
            end
            ST_LOW: begin
                if (!en) begin
                    st_d  = ST_IDLE;        // abort
                    cnt_d = ZERO;
                end else if (cnt_q == lo_last) begin
                    st_d  = ST_HIGH;        // mid
                    cnt_d = ZERO;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            ST_HIGH: begin
                if (!en) begin
                    st_d  = ST_IDLE;        // abort
                    cnt_d = ZERO;
                end else if (cnt_q == hi_last) begin
                    cnt_d = ZERO;
                    if (reload_in == ZERO) begin
                        st_d = ST_IDLE;     // stop
                    end else begin
                        st_d = ST_LOW;      // wrap
                        ld   = 1'b1;
                    end
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            default: begin
                st_d  = ST_IDLE;
                cnt_d = ZERO;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            cnt_q     <= ZERO;
            cur_rl_q  <= ZERO;
            cur_inv_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (ld) begin
                cur_rl_q  <= reload_in;
                cur_inv_q <= invert_in;
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= 1'b1;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            sck_q  <= (st_d != ST_LOW);
            rise_q <= (st_q == ST_LOW) && (st_d != ST_LOW);
            fall_q <= (st_q != ST_LOW) && (st_d == ST_LOW);
        end
    end

    assign sck_o  = sck_q;
    assign rise_o = rise_q;
    assign fall_o = fall_q;

    // ---------------- checker state and assertions ----------------
    logic [CW-1:0] chk_len, chk_low, chk_ratio;
    logic          chk_inv, chk_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_len   <= '0;
            chk_low   <= '0;
            chk_ratio <= '0;
            chk_inv   <= 1'b0;
            chk_valid <= 1'b0;
        end else begin
            if (fall_q) begin
                chk_len   <= CW'(1);
                chk_low   <= CW'(1);
                chk_ratio <= {2'b00, cur_rl_q} + CW'(1);
                chk_inv   <= cur_inv_q;
                chk_valid <= 1'b1;
            end else begin
                chk_len <= chk_len + CW'(1);
                if (!sck_q) chk_low <= chk_low + CW'(1);
                if (st_q == ST_IDLE) chk_valid <= 1'b0;
            end
        end
    end

    assert_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_q && chk_valid) |-> (chk_len == chk_ratio));

    assert_equal_halves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_q && chk_valid && !chk_ratio[0]) |-> ((chk_low << 1) == chk_ratio));

    assert_high_longer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_q && chk_valid && chk_ratio[0] && !chk_inv) |-> (((chk_low << 1) + CW'(1)) == chk_ratio));

    assert_low_longer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_q && chk_valid && chk_ratio[0] && chk_inv) |-> ((chk_low << 1) == (chk_ratio + CW'(1))));

    assert_zero_no_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && reload_in == ZERO) |=> (sck_q && !fall_q));

    assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (sck_q && !fall_q));

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_q, fall_q}));

    assert_fall_marks_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fall_q |-> (!sck_q && $past(sck_q)));

    assert_rise_marks_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q |-> (sck_q && !$past(sck_q)));

    assert_start_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && en && reload_in != ZERO) |=> fall_q);

endmodule

// File: rtl/sclk_reload_gen.sv
module sclk_reload_gen #(
    parameter int RW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [RW-1:0] reload,
    input  logic          invert,
    output logic          tx_sck,
    output logic          tx_rise,
    output logic          tx_fall,
    output logic          rx_sck,
    output logic          rx_rise,
    output logic          rx_fall
);
    localparam int NCH = 2;   // index 0: transmit, index 1: receive

    logic [NCH-1:0] sck_v, rise_v, fall_v;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        sclk_chan #(.RW(RW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (enable),
            .reload_in (reload),
            .invert_in (invert),
            .sck_o     (sck_v[g]),
            .rise_o    (rise_v[g]),
            .fall_o    (fall_v[g])
        );
    end

    assign tx_sck  = sck_v[0];
    assign tx_rise = rise_v[0];
    assign tx_fall = fall_v[0];
    assign rx_sck  = sck_v[1];
    assign rx_rise = rise_v[1];
    assign rx_fall = fall_v[1];

    assert_chan_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sck == rx_sck) && (tx_rise == rx_rise) && (tx_fall == rx_fall));

endmodule

// File: tb/sclk_reload_gen_tb.sv
`timescale 1ns/1ps
module sclk_reload_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        inv = 1'b0;
    logic [14:0] rl = '0;
    logic tx_sck, tx_rise, tx_fall, rx_sck, rx_rise, rx_fall;

    int n_chk = 0;
    int n_fail = 0;
    int sterr = 0;
    bit mism = 1'b0;

    always #2 clk = ~clk;

    sclk_reload_gen u_dut (
        .clk(clk), .rst_n(rst_n), .enable(en), .reload(rl), .invert(inv),
        .tx_sck(tx_sck), .tx_rise(tx_rise), .tx_fall(tx_fall),
        .rx_sck(rx_sck), .rx_rise(rx_rise), .rx_fall(rx_fall)
    );

    always @(negedge clk)
        if (rst_n && ((tx_sck != rx_sck) || (tx_rise != rx_rise) || (tx_fall != rx_fall)))
            mism = 1'b1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Counts cycles at level lvl starting at the current negedge; returns at
    // the first sample of the other level (or after lim cycles).
    task automatic phase(input bit lvl, input int lim, output int n);
        bit done = 1'b0;
        n = 1;
        while (!done && n < lim) begin
            @(negedge clk);
            if (tx_sck == lvl) begin
                n++;
                if (tx_rise || tx_fall) sterr++;
            end else begin
                done = 1'b1;
            end
        end
    endtask

    function automatic int exp_lo(input int v, input bit iv);
        int r = v + 1;
        if (r % 2 == 0) return r / 2;
        return iv ? (r + 1) / 2 : (r - 1) / 2;
    endfunction

    function automatic int exp_hi(input int v, input bit iv);
        return (v + 1) - exp_lo(v, iv);
    endfunction

    task automatic run_case(input int v, input bit iv);
        int lo, hi;
        string tag;
        tag = (v % 2 == 1) ? "R3" : (iv ? "R5" : "R4");
        @(negedge clk);
        rl = 15'(v); inv = iv; en = 1'b1; mism = 1'b0; sterr = 0;
        @(negedge clk);
        chk(tx_fall && !tx_sck, "R10 first fall", {tx_fall, tx_sck}, 2);
        for (int p = 0; p < 2; p++) begin
            phase(1'b0, 70000, lo);
            chk(lo == exp_lo(v, iv), tag, lo, exp_lo(v, iv));
            chk(tx_rise && tx_sck, "R9 rise strobe", tx_rise, 1);
            phase(1'b1, 70000, hi);
            chk(hi == exp_hi(v, iv), tag, hi, exp_hi(v, iv));
            chk(tx_fall && !tx_sck, "R9 fall strobe", tx_fall, 1);
            chk(lo + hi == v + 1, "R1 period", lo + hi, v + 1);
        end
        en = 1'b0;                       // abort in LOW
        @(negedge clk);
        chk(tx_sck && tx_rise, "R9 abort rise", {tx_sck, tx_rise}, 3);
        @(negedge clk);
        chk(tx_sck && !tx_rise && !tx_fall, "R7 idle", {tx_sck, tx_rise, tx_fall}, 4);
        chk(sterr == 0, "R9 single-cycle strobes", sterr, 0);
        chk(!mism, "R6 channel match", mism, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_up();
    end

    initial begin
        int lo, hi, act;
        repeat (3) @(negedge clk);
        chk(tx_sck && !tx_rise && !tx_fall, "R7 reset state", {tx_sck, tx_rise, tx_fall}, 4);
        rst_n = 1'b1;

        // R7: enable low holds the clock at rest
        rl = 15'd5;
        act = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!tx_sck || tx_rise || tx_fall) act++;
        end
        chk(act == 0, "R7 held while disabled", act, 0);

        // Sweep of small ratios, both inversion settings (R1 R3 R4 R5 R9 R10)
        for (int v = 1; v <= 40; v++)
            for (int iv = 0; iv < 2; iv++)
                run_case(v, iv[0]);

        // Full-width baud examples (R1)
        run_case(129, 1'b0);
        run_case(832, 1'b0);
        run_case(832, 1'b1);

        // R8: reload change mid-period
        @(negedge clk);
        rl = 15'd9; inv = 1'b0; en = 1'b1;
        @(negedge clk);
        rl = 15'd4;
        phase(1'b0, 1000, lo);
        chk(lo == 5, "R8 old low kept", lo, 5);
        phase(1'b1, 1000, hi);
        chk(hi == 5, "R8 old high kept", hi, 5);
        phase(1'b0, 1000, lo);
        chk(lo == 2, "R8 new low", lo, 2);
        phase(1'b1, 1000, hi);
        chk(hi == 3, "R8 new high", hi, 3);
        en = 1'b0;
        repeat (3) @(negedge clk);

        // R11: zero reload while running stops after the HIGH phase
        rl = 15'd5; inv = 1'b1; en = 1'b1; sterr = 0;
        @(negedge clk);
        rl = 15'd0;
        phase(1'b0, 1000, lo);
        chk(lo == 3, "R11 last low", lo, 3);
        phase(1'b1, 40, hi);
        chk(hi == 40, "R11 stays high", hi, 40);
        chk(sterr == 0, "R11 no strobes", sterr, 0);
        en = 1'b0;
        repeat (3) @(negedge clk);

        // R2: start refused with reload 0
        rl = 15'd0; en = 1'b1;
        act = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!tx_sck || tx_rise || tx_fall) act++;
        end
        chk(act == 0, "R2 zero reload idle", act, 0);
        en = 1'b0;
        repeat (3) @(negedge clk);

        finish_up();
    end
endmodule